// File: doc/BRIEF.md
# Data-Dependent Hash Chain Engine

This engine takes a 256-bit seed and runs it through a fixed number of mixing rounds. In each round it applies one function from a bank of several. It does not follow a set order. The function for each round is chosen by the result of the round before it. A 32-bit tag, taken from the hash of the previous block, chooses the first function. The seed itself plays no part in that first choice.

Every round takes one clock cycle. The running state and the index of the next function sit together in one register and are updated at the same edge. The mixing functions are small stand-ins made of rotates, XORs and adds. A caller raises `start_valid` with the seed and tag while the engine is idle. It then waits for a one-cycle `done` pulse and reads `result_state`, which holds its value until the next accepted start.

Top module: `hash_chain_engine`

## Requirements
- R1: When `start_valid` is high at a rising edge while `busy` is low, the engine captures `seed_state` and sets the first function index to `chain_tag % NUM_FN`. That index depends only on the tag, never on the seed.
- R2: Each busy cycle performs one round. It replaces the state with `F_k(state)`, where k is the stored index. In the same edge it stores the next index, which is bits [31:0] of the new state modulo `NUM_FN`.
- R3: State word w is bits [32w+31:32w], and the state has 8 words. Function k maps word w to `rotl(s[w] ^ s[(w+1)%8], (5k+3)%31+1) + (s[(w+k+2)%8] ^ C_k)`. Here C_k is the low 32 bits of `32'h9E3779B9*(k+1)`.
- R4: A chain runs exactly `NUM_ROUNDS` rounds. `done` goes high after the `NUM_ROUNDS`-th rising edge that follows the accepting edge.
- R5: `done` is high for exactly one cycle per chain.
- R6: `busy` is high from the accepting edge until the last round. A `start_valid` raised while busy has no effect on the result or on the timing.
- R7: `result_state` shows the final state after `done` and holds it until the next accepted start.
- R8: A synchronous active-low reset clears the state, the function index, the round counter, `busy` and `done`. A reset during a chain aborts it.
- R9: The defaults are `NUM_FN` = 10 functions and `NUM_ROUNDS` = 10 rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | Request to start a chain; taken only while idle |
| seed_state | input | 256 | Initial state of the chain |
| chain_tag | input | 32 | Value from the previous block's hash; chooses the first function |
| busy | output | 1 | A chain is in progress |
| done | output | 1 | One-cycle pulse when the chain ends |
| result_state | output | 256 | Current or final state; held while idle |

## Verification
The properties assume `start_valid` is sampled only at clock edges. They also assume that, without a start, nothing but reset changes the engine. The bench drives every input on the falling edge, so each value is stable when the rising edge samples it. It also raises `start_valid` in the middle of a chain to test that the engine ignores it. The stored function index must stay below `NUM_FN` at all times. This holds because the engine loads the index only through the two modulo reductions.

// File: rtl/hc_pkg.sv
// Package for the hash chain engine. It holds the word width and the
// helpers that give each mixing function its own rotation and constant.
// Assumes: function indices are small non-negative integers.
package hc_pkg;
    localparam int WORD_W = 32;

    // Rotates a word left by r bits, where 1 <= r <= 31.
    function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] x, input int unsigned r);
        return (x << r) | (x >> (WORD_W - r));
    endfunction

    // Rotation amount used by function k.
    function automatic int unsigned fn_rot(input int unsigned k);
        return ((5 * k + 3) % 31) + 1;
    endfunction

    // Additive constant used by function k.
    function automatic logic [WORD_W-1:0] fn_const(input int unsigned k);
        logic [63:0] p;
        p = 64'h0000_0000_9E37_79B9 * 64'(k + 1);
        return p[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/hc_mix_bank.sv
// Bank of mixing functions. Every function is evaluated on the same state
// in parallel, and a later multiplexer takes one result.
// Assumes: N_WORDS >= 2. The inputs are the registered state, so there is no
// combinational path from the output back to the input.
module hc_mix_bank #(
    parameter int N_FN    = 10,
    parameter int N_WORDS = 8,
    localparam int ST_W   = N_WORDS * hc_pkg::WORD_W
) (
    input  logic [ST_W-1:0]            st_i,
    output logic [N_FN-1:0][ST_W-1:0]  cand_o
);
    import hc_pkg::*;

    // One candidate per function and one word per candidate.
    for (genvar f = 0; f < N_FN; f++) begin : g_fn
        for (genvar w = 0; w < N_WORDS; w++) begin : g_word
            localparam int WB = (w + 1) % N_WORDS;
            localparam int WC = (w + f + 2) % N_WORDS;
            logic [WORD_W-1:0] wa, wb, wc;
            assign wa = st_i[w*WORD_W +: WORD_W];
            assign wb = st_i[WB*WORD_W +: WORD_W];
            assign wc = st_i[WC*WORD_W +: WORD_W];
            assign cand_o[f][w*WORD_W +: WORD_W] =
                rotl32(wa ^ wb, fn_rot(f)) + (wc ^ fn_const(f));
        end
    end
endmodule

// File: rtl/hc_pick.sv
// Chooses the candidate named by the stored index. It also reduces the low
// word of the chosen candidate to give the index for the next round.
// Assumes: sel_i < N_FN, and N_FN >= 2.
module hc_pick #(
    parameter int N_FN  = 10,
    parameter int ST_W  = 256,
    localparam int SEL_W = $clog2(N_FN)
) (
    input  logic [N_FN-1:0][ST_W-1:0] cand_i,
    input  logic [SEL_W-1:0]          sel_i,
    output logic [ST_W-1:0]           nxt_state_o,
    output logic [SEL_W-1:0]          nxt_sel_o
);
    logic [31:0] low_word;
    logic [31:0] low_mod;

    // Selects the function output and works out the next index.
    always_comb begin
        nxt_state_o = cand_i[sel_i];
        low_word    = nxt_state_o[31:0];
        low_mod     = low_word % 32'(N_FN);
        nxt_sel_o   = low_mod[SEL_W-1:0];
    end
endmodule

// File: rtl/hc_seq.sv
// Round sequencer. It accepts a start while idle, counts the rounds and
// raises done for one cycle after the last round.
// Assumes: N_ROUNDS >= 1. Reset is synchronous and active low.
module hc_seq #(
    parameter int N_ROUNDS = 10,
    localparam int CNT_W   = $clog2(N_ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    output logic             load_o,
    output logic             step_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] rnd_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_ROUNDS - 1);

    logic             busy_q, done_q;
    logic [CNT_W-1:0] rnd_q;

    assign load_o = start_valid && !busy_q;
    assign step_o = busy_q;
    assign busy_o = busy_q;
    assign done_o = done_q;
    assign rnd_o  = rnd_q;

    // Holds the run flag, the round count and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                rnd_q  <= '0;
            end else if (busy_q) begin
                if (rnd_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rnd_q  <= '0;
                end else begin
                    rnd_q <= rnd_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hash_chain_engine.sv
// Top of the data-dependent hash chain. One register holds the 256-bit state
// together with the index of the next function. Each busy cycle applies one
// function and stores the next index in the same edge.
// Assumes: NUM_FN >= 2, NUM_ROUNDS >= 1, N_WORDS >= 2.
module hash_chain_engine #(
    parameter int NUM_FN     = 10,
    parameter int NUM_ROUNDS = 10,
    parameter int N_WORDS    = 8,
    localparam int ST_W      = N_WORDS * hc_pkg::WORD_W,
    localparam int SEL_W     = $clog2(NUM_FN),
    localparam int CNT_W     = $clog2(NUM_ROUNDS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_valid,
    input  logic [ST_W-1:0] seed_state,
    input  logic [31:0]     chain_tag,
    output logic            busy,
    output logic            done,
    output logic [ST_W-1:0] result_state
);
    logic [ST_W-1:0]             state_q;
    logic [SEL_W-1:0]            sel_q;
    logic [NUM_FN-1:0][ST_W-1:0] cand;
    logic [ST_W-1:0]             nxt_state;
    logic [SEL_W-1:0]            nxt_sel;
    logic [SEL_W-1:0]            tag_sel;
    logic [31:0]                 tag_mod;
    logic                        load, step;
    logic [CNT_W-1:0]            rnd;

    hc_seq #(.N_ROUNDS(NUM_ROUNDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .load_o(load), .step_o(step), .busy_o(busy), .done_o(done), .rnd_o(rnd)
    );

    hc_mix_bank #(.N_FN(NUM_FN), .N_WORDS(N_WORDS)) u_bank (
        .st_i(state_q), .cand_o(cand)
    );

    hc_pick #(.N_FN(NUM_FN), .ST_W(ST_W)) u_pick (
        .cand_i(cand), .sel_i(sel_q), .nxt_state_o(nxt_state), .nxt_sel_o(nxt_sel)
    );

    // Reduces the tag to the index of the first function.
    always_comb begin
        tag_mod = chain_tag % 32'(NUM_FN);
        tag_sel = tag_mod[SEL_W-1:0];
    end

    // Updates the state and the next index together at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            sel_q   <= '0;
        end else if (load) begin
            state_q <= seed_state;
            sel_q   <= tag_sel;
        end else if (step) begin
            state_q <= nxt_state;
            sel_q   <= nxt_sel;
        end
    end

    assign result_state = state_q;
endmodule

// File: rtl/hash_chain_engine_chk.sv
// Checker for hash_chain_engine, bound to every instance of it.
// Assumes: it sees the top ports, the stored index and the round count.
module hash_chain_engine_chk #(
    parameter int NUM_FN     = 10,
    parameter int NUM_ROUNDS = 10,
    parameter int ST_W       = 256,
    localparam int SEL_W     = $clog2(NUM_FN),
    localparam int CNT_W     = $clog2(NUM_ROUNDS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_valid,
    input logic             busy,
    input logic             done,
    input logic [ST_W-1:0]  result_state,
    input logic [SEL_W-1:0] sel_q,
    input logic [CNT_W-1:0] rnd
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS - 1);

    // R2: the stored index is always a legal function number
    a_r2_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_q) < NUM_FN);

    // R4: the round count stays below the round limit
    a_r4_rnd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rnd) < NUM_ROUNDS);

    // R5: done lasts one cycle
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done only follows a busy cycle
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    // R6: a start while idle makes the engine busy
    a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && !busy) |=> busy);

    // R6: while busy the count advances by one regardless of start_valid
    a_r6_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rnd != LAST) |=> (busy && (rnd - $past(rnd)) == CNT_W'(1)));

    // R7: with no start, an idle engine holds its result
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_valid) |=> $stable(result_state));
endmodule

bind hash_chain_engine hash_chain_engine_chk #(
    .NUM_FN(NUM_FN), .NUM_ROUNDS(NUM_ROUNDS), .ST_W(ST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .busy(busy),
    .done(done), .result_state(result_state), .sel_q(sel_q), .rnd(rnd)
);

// File: tb/hash_chain_engine_bench.sv
module hash_chain_engine_bench;
    localparam int NF = 10;
    localparam int NR = 10;
    localparam int NV = 6;

    localparam logic [255:0] SEEDS [NV] = '{
        256'h0,
        {8{32'hFFFF_FFFF}},
        {32'h0123_4567, 32'h89AB_CDEF, 32'hDEAD_BEEF, 32'hCAFE_F00D,
         32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888},
        {4{64'hA5A5_5A5A_0F0F_F0F0}},
        {224'h0, 32'h0000_0001},
        {32'h8000_0000, 224'h0}
    };
    localparam logic [31:0] TAGS [NV] = '{
        32'd0, 32'd9, 32'd123457, 32'hFFFF_FFFF, 32'd5, 32'd42
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_valid = 1'b0;
    logic [255:0] seed_state = '0;
    logic [31:0]  chain_tag = '0;
    logic         busy, done;
    logic [255:0] result_state;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hash_chain_engine u_hash_chain_engine (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .seed_state(seed_state), .chain_tag(chain_tag),
        .busy(busy), .done(done), .result_state(result_state)
    );

    // Model of one round, written from the R3 formula.
    function automatic logic [255:0] ref_round(input logic [255:0] s, input int k);
        logic [255:0] o;
        int r;
        logic [63:0] prod;
        logic [31:0] a, b, c, x;
        logic [63:0] dbl;
        r = ((5 * k + 3) % 31) + 1;
        prod = 64'h9E37_79B9 * 64'(k + 1);
        for (int w = 0; w < 8; w++) begin
            a = s[32*w +: 32];
            b = s[32*((w + 1) % 8) +: 32];
            c = s[32*((w + k + 2) % 8) +: 32];
            x = a ^ b;
            dbl = {x, x} >> (32 - r);
            o[32*w +: 32] = dbl[31:0] + (c ^ prod[31:0]);
        end
        return o;
    endfunction

    // Model of a whole chain, from R1, R2 and R4.
    function automatic logic [255:0] ref_chain(input logic [255:0] seed, input logic [31:0] tag);
        logic [255:0] s;
        int k;
        s = seed;
        k = int'(tag % 32'(NF));
        for (int i = 0; i < NR; i++) begin
            s = ref_round(s, k);
            k = int'(s[31:0] % 32'(NF));
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one chain; can pulse start mid-run with other data (R6).
    task automatic run_chain(input logic [255:0] seed, input logic [31:0] tag,
                             input bit poke, output logic [255:0] res, output int lat);
        @(negedge clk);
        start_valid = 1'b1; seed_state = seed; chain_tag = tag;
        @(negedge clk);
        start_valid = 1'b0; seed_state = ~seed; chain_tag = tag + 32'd1;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 3) start_valid = 1'b1;
            if (poke && lat == 4) start_valid = 1'b0;
        end
        res = result_state;
    endtask

    initial begin
        #2_000_000ns;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] res, exp, res2;
        int lat;

        repeat (3) @(negedge clk);
        // R8: state after reset
        check(!busy && !done && result_state == '0, "R8 reset state",
              {254'(result_state), busy, done}, '0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R9
        for (int v = 0; v < NV; v++) begin
            exp = ref_chain(SEEDS[v], TAGS[v]);
            run_chain(SEEDS[v], TAGS[v], 1'b0, res, lat);
            check(res == exp, "R2/R3 chain result", res, exp);
            check(lat == NR, "R4 latency", 256'(lat), 256'(NR));
            @(negedge clk);
            check(!done, "R5 done single cycle", 256'(done), 256'd0);
            repeat (3) @(negedge clk);
            check(result_state == exp && !busy, "R7 result held", result_state, exp);
        end

        // R1: first index comes from tag modulo 10, not from the seed
        run_chain(SEEDS[2], 32'd3, 1'b0, res, lat);
        run_chain(SEEDS[2], 32'd13, 1'b0, res2, lat);
        check(res == res2, "R1 tag modulo equal", res2, res);
        exp = ref_chain(SEEDS[2], 32'd4);
        run_chain(SEEDS[2], 32'd4, 1'b0, res2, lat);
        check(res2 == exp && res2 != res, "R1 tag picks function", res2, exp);

        // R6: start while busy has no effect
        exp = ref_chain(SEEDS[3], 32'd7);
        run_chain(SEEDS[3], 32'd7, 1'b1, res, lat);
        check(res == exp, "R6 start ignored result", res, exp);
        check(lat == NR, "R6 start ignored timing", 256'(lat), 256'(NR));

        // R8: reset during a chain aborts it
        @(negedge clk);
        start_valid = 1'b1; seed_state = SEEDS[1]; chain_tag = 32'd2;
        @(negedge clk);
        start_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && result_state == '0, "R8 mid-run reset",
              {254'(result_state), busy, done}, '0);
        rst_n = 1'b1;
        repeat (NR + 2) @(negedge clk);
        check(!done && result_state == '0, "R8 no done after abort",
              {255'(result_state), done}, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule